// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Register File

This block is the host-visible register file of a two-channel bus-master disk DMA controller. A simple byte-wide I/O port gives the host access to every register: an address, a write strobe with write data, and a read strobe with read data. Each channel has a command byte, a status byte and a 32-bit pointer to its descriptor table. The block drives the command and pointer values as levels to a separate DMA engine. It also takes the engine's activity level and its single-cycle error and interrupt event pulses and records them in the status byte.

Each channel owns an 8-byte window, and channel n starts at byte 8n. The status byte is the delicate part, because it holds three kinds of bit in one byte. Bits 5 and 6 are ordinary read/write bits. The error and interrupt flags are set by events and cleared when the host writes a one to them. The activity bit is read-only and follows the engine. The spare bytes of each window read back as all ones.

Top module: `bmide_regfile`

## Requirements
- R1: Channel n decodes byte addresses 8n to 8n+7. Offset 0 is the command byte, offset 2 is the status byte, and offsets 4 to 7 are the descriptor pointer in little-endian order (offset 4 holds bits 7:0, offset 7 holds bits 31:24). The channels are fully independent.
- R2: A read of offset 1 or 3 of any channel returns 0xFF.
- R3: A write to offset 1 or 3 changes no register.
- R4: A command write stores bit 0 (start, driven on `eng_start`) and bit 3 (direction, driven on `eng_dir`). All other command bits read back as 0.
- R5: A status write loads bits 5 and 6 from the data and clears bit 1 or bit 2 wherever the data holds a 1. Bits 3, 4 and 7 read as 0, and bit 0 is left untouched.
- R6: Status bit 0 shows `dma_active` of that channel as sampled at the previous clock edge.
- R7: An `dma_err_evt` pulse sets status bit 1 and an `dma_irq_evt` pulse sets status bit 2. Each bit stays set until it is cleared. If a set and a write-one clear land in the same cycle, the bit ends up set.
- R8: Bits 1:0 of the descriptor pointer always read as 0, whatever data is written.
- R9: A synchronous active-low reset clears the command, status and pointer registers of every channel, and it clears `io_rdata`.
- R10: `io_rdata` loads the addressed byte on a clock edge where `io_rd` is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Byte address (bit 3 selects the channel) |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Registered read data |
| dma_active | input | 2 | Per-channel engine activity level |
| dma_err_evt | input | 2 | Per-channel error event pulse |
| dma_irq_evt | input | 2 | Per-channel interrupt event pulse |
| eng_start | output | 2 | Per-channel start/stop level |
| eng_dir | output | 2 | Per-channel transfer direction level |
| eng_desc | output | 64 | Descriptor pointers, channel n in bits 32n+31:32n |

## Verification
The bench writes all ones to the status byte. A design that treats bits 1 and 2 as plain read/write bits would then show them set, and one that lets the write reach bit 0 would lose the activity mirror. It raises an interrupt pulse in the same cycle as a write-one clear of that flag, so a design that gives the clear priority would read 0 where 4 is expected. It writes to the spare offsets and reads the pointer with its low bits forced to zero. It also checks that channel 1 does not see channel 0's writes, which catches a decode that ignores address bit 3.

// File: rtl/bmide_pkg.sv
// Shared constants of the bus-master DMA register file: window layout
// and bit positions inside the command and status bytes.
package bmide_pkg;
    localparam int WIN_BITS   = 3;           // 8-byte window per channel
    localparam int DESC_W     = 32;
    localparam int DESC_BYTES = DESC_W / 8;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_PAD1 = 3'd1;
    localparam logic [2:0] OFF_STS  = 3'd2;
    localparam logic [2:0] OFF_PAD3 = 3'd3;
    localparam logic [2:0] OFF_DESC = 3'd4;

    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;
    localparam int STS_ACT   = 0;
    localparam int STS_ERR   = 1;
    localparam int STS_IRQ   = 2;
    localparam int STS_RW_LO = 5;
    localparam int STS_RW_HI = 6;

    localparam logic [7:0] PAD_BYTE = 8'hFF;
endpackage

// File: rtl/bmide_chan.sv
// One channel of the register file: command, status and descriptor pointer.
// Assumes wr_en is already qualified by the channel select, and at most one
// byte is written per cycle. Reads are combinational; the top registers them.
module bmide_chan
    import bmide_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        off,
    input  logic [7:0]        wdata,
    input  logic              active,
    input  logic              err_evt,
    input  logic              irq_evt,
    output logic [7:0]        rd_byte,
    output logic              start,
    output logic              dir,
    output logic [DESC_W-1:0] desc
);
    logic       start_q, dir_q;
    logic       act_q, err_q, irq_q;
    logic [1:0] rw_q;
    logic [DESC_W-1:0] desc_q;

    logic wr_cmd, wr_sts;
    assign wr_cmd = wr_en && (off == OFF_CMD);
    assign wr_sts = wr_en && (off == OFF_STS);

    // Command byte: only start and direction are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
        end else if (wr_cmd) begin
            start_q <= wdata[CMD_START];
            dir_q   <= wdata[CMD_DIR];
        end
    end

    // Status byte: activity mirror, sticky events (set wins), plain bits 6:5.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            rw_q  <= 2'b00;
        end else begin
            act_q <= active;
            err_q <= err_evt || (err_q && !(wr_sts && wdata[STS_ERR]));
            irq_q <= irq_evt || (irq_q && !(wr_sts && wdata[STS_IRQ]));
            if (wr_sts)
                rw_q <= wdata[STS_RW_HI:STS_RW_LO];
        end
    end

    // Descriptor pointer: byte-lane writes, low two bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else begin
            for (int b = 0; b < DESC_BYTES; b++) begin
                if (wr_en && (off == OFF_DESC + 3'(b)))
                    desc_q[8*b +: 8] <= wdata;
            end
            desc_q[1:0] <= 2'b00;
        end
    end

    // Read byte for the current offset.
    always_comb begin
        unique case (off)
            OFF_CMD:  rd_byte = {4'b0, dir_q, 2'b0, start_q};
            OFF_STS:  rd_byte = {1'b0, rw_q, 2'b0, irq_q, err_q, act_q};
            OFF_PAD1, OFF_PAD3: rd_byte = PAD_BYTE;
            default:  rd_byte = desc_q[8*off[1:0] +: 8];
        endcase
    end

    assign start = start_q;
    assign dir   = dir_q;
    assign desc  = desc_q;

    // R6
    act_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (act_q == $past(active)));
    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_q);
    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> irq_q);
    // R5
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[STS_ERR] && !err_evt) |=> !err_q);
    // R3
    pad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (off == OFF_PAD1 || off == OFF_PAD3))
        |=> ($stable(start_q) && $stable(dir_q) && $stable(rw_q) && $stable(desc_q)));
    // R8
    desc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_DESC) |=> (desc_q[7:2] == $past(wdata[7:2])));
endmodule

// File: rtl/bmide_rdport.sv
// Read-data register: captures the selected byte on a read strobe and
// holds it otherwise. Assumes the read byte is stable during the strobe cycle.
module bmide_rdport (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic [7:0] sel_byte,
    output logic [7:0] rdata
);
    // Load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= 8'h00;
        else if (rd) rdata <= sel_byte;
    end

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd)) |-> $stable(rdata));
endmodule

// File: rtl/bmide_regfile.sv
// Top of the register file: decodes the channel from the upper address bits,
// builds one channel instance per channel and registers the read byte.
// Assumes io_wr and io_rd are single-byte accesses, one per cycle.
module bmide_regfile
    import bmide_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CH_BITS = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW = CH_BITS + WIN_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         io_addr,
    input  logic                  io_wr,
    input  logic [7:0]            io_wdata,
    input  logic                  io_rd,
    output logic [7:0]            io_rdata,
    input  logic [NCH-1:0]        dma_active,
    input  logic [NCH-1:0]        dma_err_evt,
    input  logic [NCH-1:0]        dma_irq_evt,
    output logic [NCH-1:0]        eng_start,
    output logic [NCH-1:0]        eng_dir,
    output logic [NCH*DESC_W-1:0] eng_desc
);
    logic [CH_BITS-1:0] ch_sel;
    logic [7:0]         ch_rd [NCH];
    logic [7:0]         sel_byte;

    assign ch_sel = io_addr[AW-1:WIN_BITS];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmide_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (io_wr && (ch_sel == CH_BITS'(c))),
            .off     (io_addr[WIN_BITS-1:0]),
            .wdata   (io_wdata),
            .active  (dma_active[c]),
            .err_evt (dma_err_evt[c]),
            .irq_evt (dma_irq_evt[c]),
            .rd_byte (ch_rd[c]),
            .start   (eng_start[c]),
            .dir     (eng_dir[c]),
            .desc    (eng_desc[c*DESC_W +: DESC_W])
        );
    end

    // Pick the addressed channel's byte; windows with no channel read all ones.
    always_comb begin
        sel_byte = PAD_BYTE;
        for (int c = 0; c < NCH; c++)
            if (ch_sel == CH_BITS'(c)) sel_byte = ch_rd[c];
    end

    bmide_rdport u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (io_rd),
        .sel_byte (sel_byte),
        .rdata    (io_rdata)
    );

    // R2
    pad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_addr[WIN_BITS-1:0] == OFF_PAD1 || io_addr[WIN_BITS-1:0] == OFF_PAD3))
        |=> (io_rdata == PAD_BYTE));
endmodule

// File: tb/bmide_regfile_test.sv
`timescale 1ns/1ps
module bmide_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [1:0]  dma_active = '0;
    logic [1:0]  dma_err_evt = '0;
    logic [1:0]  dma_irq_evt = '0;
    logic [1:0]  eng_start, eng_dir;
    logic [63:0] eng_desc;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bmide_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
        .dma_active(dma_active), .dma_err_evt(dma_err_evt),
        .dma_irq_evt(dma_irq_evt), .eng_start(eng_start),
        .eng_dir(eng_dir), .eng_desc(eng_desc)
    );

    // {req[3:0], is_wr, addr[3:0], wdata[7:0], expected[7:0]}
    localparam int NV = 28;
    localparam logic [24:0] VEC [NV] = '{
        {4'd9,  1'b0, 4'h0, 8'h00, 8'h00},  // R9 command resets to 0
        {4'd9,  1'b0, 4'h2, 8'h00, 8'h00},  // R9 status resets to 0
        {4'd9,  1'b0, 4'h4, 8'h00, 8'h00},  // R9 pointer resets to 0
        {4'd2,  1'b0, 4'h1, 8'h00, 8'hFF},  // R2
        {4'd2,  1'b0, 4'h3, 8'h00, 8'hFF},  // R2
        {4'd2,  1'b0, 4'h9, 8'h00, 8'hFF},  // R2 channel 1
        {4'd2,  1'b0, 4'hB, 8'h00, 8'hFF},  // R2 channel 1
        {4'd4,  1'b1, 4'h0, 8'hFF, 8'h00},
        {4'd4,  1'b0, 4'h0, 8'h00, 8'h09},  // R4 only bits 3 and 0 stick
        {4'd5,  1'b1, 4'h2, 8'hFF, 8'h00},
        {4'd5,  1'b0, 4'h2, 8'h00, 8'h60},  // R5 W1C on clear bits, 6:5 loaded
        {4'd5,  1'b1, 4'h2, 8'h20, 8'h00},
        {4'd5,  1'b0, 4'h2, 8'h00, 8'h20},  // R5 plain bits rewritten
        {4'd8,  1'b1, 4'h4, 8'hFF, 8'h00},
        {4'd1,  1'b1, 4'h5, 8'h12, 8'h00},
        {4'd1,  1'b1, 4'h6, 8'h34, 8'h00},
        {4'd1,  1'b1, 4'h7, 8'h56, 8'h00},
        {4'd8,  1'b0, 4'h4, 8'h00, 8'hFC},  // R8 low bits forced to 0
        {4'd1,  1'b0, 4'h5, 8'h00, 8'h12},  // R1
        {4'd1,  1'b0, 4'h7, 8'h00, 8'h56},  // R1
        {4'd1,  1'b0, 4'hC, 8'h00, 8'h00},  // R1 channel 1 pointer untouched
        {4'd1,  1'b0, 4'h8, 8'h00, 8'h00},  // R1 channel 1 command untouched
        {4'd1,  1'b1, 4'h8, 8'h08, 8'h00},
        {4'd1,  1'b0, 4'h8, 8'h00, 8'h08},  // R1 channel 1 command
        {4'd3,  1'b1, 4'h1, 8'hAA, 8'h00},
        {4'd3,  1'b1, 4'h3, 8'hFF, 8'h00},
        {4'd3,  1'b0, 4'h0, 8'h00, 8'h09},  // R3 command unchanged
        {4'd3,  1'b0, 4'h2, 8'h00, 8'h20}   // R3 status unchanged
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(req, 64'(io_rdata), 64'(exp));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", 64'(io_rdata), 64'h0);
        check("R9", 64'({eng_start, eng_dir}), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
            else rd(VEC[i][19:16], VEC[i][7:0], $sformatf("R%0d", VEC[i][24:21]));
        end

        // R4 R1 R8 engine-side levels
        check("R4", 64'(eng_start), 64'h1);
        check("R4", 64'(eng_dir), 64'h3);
        check("R8", eng_desc, 64'h0000_0000_5634_12FC);

        // R10 read data holds with no strobe
        @(negedge clk); io_addr = 4'h1;
        @(negedge clk);
        check("R10", 64'(io_rdata), 64'h20);

        // R7 event pulses on channel 1
        @(negedge clk); dma_err_evt[1] = 1'b1;
        @(negedge clk); dma_err_evt[1] = 1'b0;
        rd(4'hA, 8'h02, "R7");
        @(negedge clk); dma_irq_evt[1] = 1'b1;
        @(negedge clk); dma_irq_evt[1] = 1'b0;
        rd(4'hA, 8'h06, "R7");
        rd(4'h2, 8'h20, "R7");          // channel 0 untouched
        wr(4'hA, 8'h02);
        rd(4'hA, 8'h04, "R5");          // W1C clears only bit 1
        wr(4'hA, 8'h04);
        rd(4'hA, 8'h00, "R5");
        // R7 set and clear in the same cycle: set wins
        @(negedge clk);
        dma_irq_evt[1] = 1'b1; io_addr = 4'hA; io_wdata = 8'h04; io_wr = 1'b1;
        @(negedge clk);
        dma_irq_evt[1] = 1'b0; io_wr = 1'b0;
        rd(4'hA, 8'h04, "R7");

        // R6 activity mirror, not writable
        @(negedge clk); dma_active[0] = 1'b1;
        rd(4'h2, 8'h21, "R6");
        wr(4'h2, 8'h00);
        rd(4'h2, 8'h01, "R6");
        @(negedge clk); dma_active[0] = 1'b0;
        rd(4'h2, 8'h00, "R6");

        // R9 reset in mid-run
        @(negedge clk); rst_n = 1'b0; dma_active = '0;
        @(negedge clk); rst_n = 1'b1;
        check("R9", 64'(io_rdata), 64'h0);
        check("R9", eng_desc, 64'h0);
        check("R9", 64'({eng_start, eng_dir}), 64'h0);
        rd(4'hA, 8'h00, "R9");
        rd(4'h0, 8'h00, "R9");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule